// File: doc/BRIEF.md
# PAM-4 Decision Level Search Controller

This controller learns two PAM-4 signal levels. The receiver then uses those levels as its references for the LSB decision. It drives the code of a threshold DAC that sets the level of an error comparator. It reads two inputs for every received symbol: the MSB decision and the output of that comparator. From these it decides whether to move the code up or down. The controller starts only once the clock recovery loop reports lock.

The search has two phases. In the first phase the code climbs toward the top of the upper data level. In the second phase it descends toward the upper edge of the middle eye. Each decision covers a fixed window of 512 valid symbols, and the code moves by at most one step per window. A window in which no qualifying symbol appears ends the phase and latches the code. After the second phase the controller raises a done flag and captures the requested reference pair selection. A per-phase budget of stepping windows ends a search that does not converge with a failure flag. Losing lock returns the controller to idle.

Top module: `lvladapt_ctrl`

## Requirements
- R1: While `cdr_lock` is low the phase output reads 0 (idle), `err_code` equals `INIT_CODE` and symbols have no effect. One clock edge after lock is seen, the phase reads 1 (top search).
- R2: A decision window is exactly `WIN_LEN` (512) cycles with `sym_valid` high. Cycles with `sym_valid` low are not counted. `err_code` changes only at the edge that takes the window's last valid symbol.
- R3: In phase 1, a window containing any valid symbol with `msb_dec`=1 and `err_above`=1 raises `err_code` by one at the window end. This includes the case where that symbol is the window's last.
- R4: In phase 1, a window with no such symbol copies `err_code` into `top_code` and moves to phase 2. Symbols with `msb_dec`=0 never qualify.
- R5: In phase 2, a window containing any valid symbol with `msb_dec`=1 and `err_above`=0 lowers `err_code` by one at the window end.
- R6: In phase 2, a window with no such symbol copies `err_code` into `mid_code`, moves to phase 3 and sets `done`.
- R7: `err_code` saturates at all-ones when stepping up and at zero when stepping down, and never wraps.
- R8: A window with many qualifying symbols moves the code by one step only.
- R9: In phase 3 the code and `done` hold whatever symbols arrive. When `cdr_lock` falls, the next edge clears `done`, returns to phase 0 and reloads `INIT_CODE`.
- R10: A phase stops stepping once it has used `tmo_limit` stepping windows. The next window with a qualifying symbol moves to phase 4 and sets `fail`, and the code holds from then until lock is lost.
- R11: At the end of phase 2, `ref_pair_sel` captures `pair_cfg`: 1 selects levels 3 and 1, 0 selects levels 0 and 2. Later changes of `pair_cfg` do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cdr_lock | input | 1 | Clock recovery lock indication |
| sym_valid | input | 1 | A symbol decision is present this cycle |
| msb_dec | input | 1 | MSB decision of the symbol |
| err_above | input | 1 | Error comparator: symbol lies above the current error level |
| pair_cfg | input | 1 | Requested LSB reference pair |
| tmo_limit | input | TMO_W | Stepping windows allowed per phase |
| err_code | output | CODE_W | Threshold DAC code |
| top_code | output | CODE_W | Learned code of the upper data level |
| mid_code | output | CODE_W | Learned code of the middle-eye upper edge |
| phase | output | 3 | 0 idle, 1 top search, 2 middle search, 3 done, 4 failed |
| done | output | 1 | Search completed |
| fail | output | 1 | Search exceeded its window budget |
| ref_pair_sel | output | 1 | Selected LSB reference pair |

## Verification
The controller updates its code, its learned levels, its phase, done, fail and the reference selection on one edge only: the edge that takes the last valid symbol of a window. Each of these results can therefore be read one cycle after that symbol is presented. A drop of lock takes effect one edge after it is seen. The bench drives each symbol on a falling edge, so the rising edge between two falling edges captures it. It checks every result on the falling edge after the capturing edge. Partial windows and idle cycles are also checked on that falling edge, to show that nothing moved early.

// File: rtl/lvladapt_pkg.sv
// Shared types for the level search controller.
// Assumes: phase encodings are visible at the top-level port and used by the bench.
package lvladapt_pkg;
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_TOP  = 3'd1,
        PH_MID  = 3'd2,
        PH_DONE = 3'd3,
        PH_FAIL = 3'd4
    } phase_t;
endpackage

// File: rtl/lvladapt_window.sv
// Observation window: counts valid symbols and remembers whether any
// qualifying event occurred. Flags the last symbol of each window.
// Assumes: clear is held while no search phase is active.
module lvladapt_window #(
    parameter int WIN_LEN = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic sym_valid,
    input  logic evt,
    output logic win_end,
    output logic win_evt
);
    localparam int CW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIN_LEN - 1);

    logic [CW-1:0] cnt;
    logic          seen;

    // Count valid symbols and accumulate the event flag within a window.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt  <= '0;
            seen <= 1'b0;
        end else if (sym_valid) begin
            if (cnt == LAST) begin
                cnt  <= '0;
                seen <= 1'b0;
            end else begin
                cnt  <= cnt + 1'b1;
                seen <= seen | evt;
            end
        end
    end

    // Window end and its combined event, including the final symbol.
    always_comb begin
        win_end = sym_valid && !clear && (cnt == LAST);
        win_evt = seen | (sym_valid & evt);
    end

    AST_WIN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> (cnt == '0)) else $error("window did not restart"); // R2

endmodule

// File: rtl/lvladapt_code.sv
// Threshold DAC code register with saturating single steps.
// Assumes: step_up and step_dn are never both high.
module lvladapt_code #(
    parameter int CODE_W    = 6,
    parameter int INIT_CODE = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reload,
    input  logic              step_up,
    input  logic              step_dn,
    output logic [CODE_W-1:0] code
);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] CODE_INI = CODE_W'(INIT_CODE);

    // Load the start code or apply one saturating step.
    always_ff @(posedge clk) begin
        if (!rst_n || reload) begin
            code <= CODE_INI;
        end else if (step_up && code != CODE_MAX) begin
            code <= code + 1'b1;
        end else if (step_dn && code != '0) begin
            code <= code - 1'b1;
        end
    end

    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !reload) |=> (code == $past(code) || code == $past(code) + 1'b1
                                || code == $past(code) - 1'b1)) else $error("code jump"); // R8
    AST_NO_WRAP_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !reload && code == CODE_MAX) |=> (code != '0)) else $error("wrap up"); // R7
    AST_NO_WRAP_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !reload && code == '0) |=> (code != CODE_MAX)) else $error("wrap down"); // R7

endmodule

// File: rtl/lvladapt_ctrl.sv
// Level search controller: after lock, climbs the error level to the top
// data level, then descends to the middle-eye upper edge, one step per
// window at most, and latches each result on a window without events.
// Assumes: err_above reports the symbol above the level set by err_code.
module lvladapt_ctrl #(
    parameter int WIN_LEN   = 512,
    parameter int CODE_W    = 6,
    parameter int INIT_CODE = 32,
    parameter int TMO_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cdr_lock,
    input  logic              sym_valid,
    input  logic              msb_dec,
    input  logic              err_above,
    input  logic              pair_cfg,
    input  logic [TMO_W-1:0]  tmo_limit,
    output logic [CODE_W-1:0] err_code,
    output logic [CODE_W-1:0] top_code,
    output logic [CODE_W-1:0] mid_code,
    output logic [2:0]        phase,
    output logic              done,
    output logic              fail,
    output logic              ref_pair_sel
);
    import lvladapt_pkg::*;

    phase_t           ph;
    logic [TMO_W-1:0] tries;
    logic             active, evt, win_end, win_evt, budget_out;
    logic             step_up, step_dn, reload;

    // Event qualification per phase and step requests.
    always_comb begin
        active     = cdr_lock && (ph == PH_TOP || ph == PH_MID);
        evt        = (ph == PH_TOP) ? (msb_dec &  err_above) :
                     (ph == PH_MID) ? (msb_dec & ~err_above) : 1'b0;
        budget_out = (tries == tmo_limit);
        step_up    = active && ph == PH_TOP && win_end && win_evt && !budget_out;
        step_dn    = active && ph == PH_MID && win_end && win_evt && !budget_out;
        reload     = !cdr_lock || ph == PH_IDLE;
    end

    lvladapt_window #(.WIN_LEN(WIN_LEN)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (!active),
        .sym_valid (sym_valid),
        .evt       (evt),
        .win_end   (win_end),
        .win_evt   (win_evt)
    );

    lvladapt_code #(.CODE_W(CODE_W), .INIT_CODE(INIT_CODE)) u_code (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload  (reload),
        .step_up (step_up),
        .step_dn (step_dn),
        .code    (err_code)
    );

    // Phase sequencing, budget counting and result latching.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph           <= PH_IDLE;
            tries        <= '0;
            top_code     <= '0;
            mid_code     <= '0;
            ref_pair_sel <= 1'b0;
        end else if (!cdr_lock) begin
            ph    <= PH_IDLE;
            tries <= '0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    ph    <= PH_TOP;
                    tries <= '0;
                end
                PH_TOP, PH_MID: begin
                    if (win_end) begin
                        if (win_evt) begin
                            if (budget_out) ph <= PH_FAIL;
                            else            tries <= tries + 1'b1;
                        end else begin
                            tries <= '0;
                            if (ph == PH_TOP) begin
                                top_code <= err_code;
                                ph       <= PH_MID;
                            end else begin
                                mid_code     <= err_code;
                                ref_pair_sel <= pair_cfg;
                                ph           <= PH_DONE;
                            end
                        end
                    end
                end
                default: ph <= ph;
            endcase
        end
    end

    // Status decode from the phase register.
    always_comb begin
        phase = ph;
        done  = (ph == PH_DONE);
        fail  = (ph == PH_FAIL);
    end

    AST_IDLE_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !cdr_lock |=> (phase == 3'd0)) else $error("active without lock"); // R1
    AST_DONE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(cdr_lock)) else $error("done without lock"); // R9
    AST_DONE_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail)) else $error("done and fail together"); // R10
    AST_FAIL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && cdr_lock) |=> $stable(err_code)) else $error("code moved after fail"); // R10

endmodule

// File: tb/lvladapt_ctrl_tb.sv
module lvladapt_ctrl_tb;
    localparam int WIN = 512;
    localparam int CW  = 4;
    localparam int INI = 8;
    localparam int TW  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cdr_lock = 1'b0, sym_valid = 1'b0, msb_dec = 1'b0, err_above = 1'b0;
    logic pair_cfg = 1'b1;
    logic [TW-1:0] tmo_limit = 5'd31;
    logic [CW-1:0] err_code, top_code, mid_code;
    logic [2:0] phase;
    logic done, fail, ref_pair_sel;

    int n_tests = 0, n_fail = 0, exp_code = INI;
    bit finished = 0;

    always #10 clk = ~clk;

    lvladapt_ctrl #(.WIN_LEN(WIN), .CODE_W(CW), .INIT_CODE(INI), .TMO_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cdr_lock(cdr_lock), .sym_valid(sym_valid),
        .msb_dec(msb_dec), .err_above(err_above), .pair_cfg(pair_cfg),
        .tmo_limit(tmo_limit), .err_code(err_code), .top_code(top_code),
        .mid_code(mid_code), .phase(phase), .done(done), .fail(fail),
        .ref_pair_sel(ref_pair_sel)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic sym(input logic v, input logic m, input logic e);
        @(negedge clk);
        sym_valid = v; msb_dec = m; err_above = e;
    endtask

    // One full window; nev>0 places an event on the last symbol and nev-1 at the start.
    task automatic win(input int nev, input logic pol, input bit gaps);
        for (int i = 0; i < WIN; i++) begin
            if (gaps && (i % 64) == 5) sym(1'b0, 1'b1, pol);
            if ((nev > 0 && i == WIN - 1) || i < nev - 1) sym(1'b1, 1'b1, pol);
            else if (i % 2) sym(1'b1, 1'b0, pol);
            else sym(1'b1, 1'b1, ~pol);
        end
        sym(1'b0, 1'b0, 1'b0);
    endtask

    function automatic int up(input int c);
        return (c < 15) ? c + 1 : 15;
    endfunction
    function automatic int dn(input int c);
        return (c > 0) ? c - 1 : 0;
    endfunction

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset phase", phase, 0);
        check("R1 reset code", err_code, INI);
        check("R1 reset done", done, 0);
        check("R10 reset fail", fail, 0);
        win(WIN, 1'b1, 0);
        check("R1 no lock phase", phase, 0);
        check("R1 no lock code", err_code, INI);

        @(negedge clk); cdr_lock = 1'b1;
        sym(1'b0, 1'b0, 1'b0);
        check("R1 start after lock", phase, 1);

        // R2: partial window with gaps leaves code; last symbol completes it.
        for (int i = 0; i < WIN - 1; i++) begin
            if (i % 50 == 7) sym(1'b0, 1'b1, 1'b1);
            sym(1'b1, 1'b1, 1'b1);
        end
        sym(1'b0, 1'b1, 1'b1);
        check("R2 partial window holds", err_code, INI);
        sym(1'b1, 1'b0, 1'b0);
        sym(1'b0, 1'b0, 1'b0);
        exp_code = up(exp_code);
        check("R2 R3 step at window end", err_code, exp_code);

        win(WIN, 1'b1, 0); exp_code = up(exp_code);
        check("R8 many events one step", err_code, exp_code);
        win(1, 1'b1, 1); exp_code = up(exp_code);
        check("R3 last symbol event", err_code, exp_code);
        for (int k = 0; k < 6; k++) begin win(4, 1'b1, 0); exp_code = up(exp_code); end
        check("R7 saturate high", err_code, 15);
        check("R7 saturate high model", err_code, exp_code);

        win(0, 1'b1, 1);
        check("R4 top latched", top_code, 15);
        check("R4 phase two", phase, 2);
        check("R4 code held", err_code, 15);

        win(3, 1'b0, 0); exp_code = dn(exp_code);
        check("R5 step down", err_code, exp_code);
        for (int k = 0; k < 16; k++) begin win(2, 1'b0, 0); exp_code = dn(exp_code); end
        check("R7 saturate low", err_code, 0);

        win(0, 1'b0, 1);
        check("R6 mid latched", mid_code, 0);
        check("R6 done", done, 1);
        check("R6 phase done", phase, 3);
        check("R11 pair captured", ref_pair_sel, 1);

        pair_cfg = 1'b0;
        win(WIN, 1'b1, 0);
        check("R9 code holds in done", err_code, 0);
        check("R9 done holds", done, 1);
        check("R11 pair held", ref_pair_sel, 1);

        @(negedge clk); cdr_lock = 1'b0;
        @(negedge clk);
        check("R9 lock loss done", done, 0);
        check("R9 lock loss phase", phase, 0);
        check("R9 lock loss code", err_code, INI);

        // R10: budget of two stepping windows.
        tmo_limit = 5'd2; cdr_lock = 1'b1;
        sym(1'b0, 1'b0, 1'b0);
        win(5, 1'b1, 0); win(5, 1'b1, 0);
        check("R10 steps within budget", err_code, INI + 2);
        check("R10 not failed yet", fail, 0);
        win(5, 1'b1, 0);
        check("R10 fail flag", fail, 1);
        check("R10 fail phase", phase, 4);
        check("R10 code held at fail", err_code, INI + 2);
        win(5, 1'b1, 0);
        check("R10 code frozen", err_code, INI + 2);

        @(negedge clk); cdr_lock = 1'b0;
        @(negedge clk);
        check("R10 fail cleared by lock loss", fail, 0);
        tmo_limit = 5'd31; cdr_lock = 1'b1;
        sym(1'b0, 1'b0, 1'b0);
        win(0, 1'b1, 0);
        win(0, 1'b0, 0);
        check("R6 quick done", done, 1);
        check("R4 top at init", top_code, INI);
        check("R11 pair zero captured", ref_pair_sel, 0);
        report();
    end
endmodule